// File: doc/BRIEF.md
# Instruction Machine-Cycle Sequencer

This block is the control sequencer for a small slice of an 8-bit accumulator machine. It owns a 16-bit program counter and four byte registers (accumulator A, B, H and L), and it drives a separate bus cycle generator one machine cycle at a time. Each instruction begins with an opcode fetch at the program counter. The decoded opcode then decides how many further cycles follow and what kind they are: operand reads at the following addresses, or a read or write at the address held in the H/L pair.

The request side is a valid/ready stream. The sequencer raises `req_valid` with the cycle kind, address and write data. It holds all of them unchanged until the generator accepts them with `req_ready` in the same clock. The generator may stall acceptance for any number of cycles; that is the only back-pressure.

After acceptance the sequencer keeps `req_valid` low until the generator reports completion with a one-cycle `rsp_valid`, which carries the byte read for read and fetch cycles. When an instruction's last cycle completes, the block pulses `retire_valid` with the opcode and its total T-state count. The count is 4 for the fetch plus 3 for each further cycle.

Top module: `instr_mcycle_seq`

## Requirements
- R1: While `rst` is high and right after it falls, the program counter and A, B, H, L read zero, `retire_valid` is low, and the request offered is a fetch (`req_type` 0) at address 0.
- R2: A request held with `req_ready` low keeps `req_valid`, `req_type`, `req_addr` and `req_wdata` stable. Once accepted, `req_valid` stays low until `rsp_valid` has been seen.
- R3: Every instruction starts with a fetch at the program counter. The counter advances by one after each opcode byte and each immediate byte is returned, and never changes otherwise.
- R4: Opcode 78h copies B into A using only the fetch and retires with 4 T-states.
- R5: Opcode 3Eh issues one read (`req_type` 1) at the next address, loads the byte into A and retires with 7 T-states.
- R6: Opcode 06h issues one read at the next address, loads the byte into B and retires with 7 T-states.
- R7: Opcode 21h issues two reads at consecutive addresses following the opcode. The first byte goes to L and the second to H, and the instruction retires with 10 T-states.
- R8: Opcode 7Eh issues one read at address {H, L} (H is the upper byte), loads the byte into A, leaves the counter one past the opcode and retires with 7 T-states.
- R9: Opcode 77h issues one write (`req_type` 2) of A to address {H, L} and retires with 7 T-states.
- R10: Any other opcode uses only the fetch, changes no register and retires with 4 T-states.
- R11: `retire_valid` is a single-cycle pulse one clock after the last `rsp_valid` of an instruction is sampled. Register and counter updates from that response appear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | output | 1 | Machine-cycle request offered |
| req_ready | input | 1 | Bus cycle generator accepts the request |
| req_type | output | 2 | 0 fetch, 1 memory read, 2 memory write |
| req_addr | output | 16 | Cycle address |
| req_wdata | output | 8 | Byte to write (write cycles only, else 0) |
| rsp_valid | input | 1 | Cycle complete (one-cycle pulse) |
| rsp_data | input | 8 | Byte returned by fetch or read cycles |
| retire_valid | output | 1 | Instruction finished |
| retire_opcode | output | 8 | Opcode of the finished instruction |
| retire_tstates | output | 4 | Total T-states of the finished instruction |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Register A |
| breg_o | output | 8 | Register B |
| hreg_o | output | 8 | Register H |
| lreg_o | output | 8 | Register L |

## Verification
Request fields are combinational from the sequencer state. They are valid in the same cycle the state enters issue, and `req_valid` drops one clock after the edge that samples `req_ready`. Retirement, register loads and counter steps appear one clock after the edge that samples `rsp_valid`. The bench drives all inputs on falling edges and reads results at the next falling edge after each such sampling edge. It checks request fields at each falling edge while they wait for acceptance and during the response gap, and checks retirement exactly at the falling edge after the final response.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // machine-cycle kinds carried on req_type
  typedef enum logic [1:0] {
    MC_FETCH = 2'd0,
    MC_MEMRD = 2'd1,
    MC_MEMWR = 2'd2
  } mc_kind_e;

  // instruction classes recognised by the decoder
  typedef enum logic [2:0] {
    OPK_NOP,
    OPK_MOVAB,
    OPK_MVIA,
    OPK_MVIB,
    OPK_LXIH,
    OPK_LDIND,
    OPK_STIND
  } op_kind_e;

  // register file selectors
  typedef enum logic [1:0] {
    RS_A = 2'd0,
    RS_B = 2'd1,
    RS_H = 2'd2,
    RS_L = 2'd3
  } reg_sel_e;

  localparam int MAX_EXTRA = 2;
  localparam int T_FETCH   = 4;
  localparam int T_MEM     = 3;
  localparam int TS_W      = $clog2(T_FETCH + MAX_EXTRA * T_MEM + 1);
  localparam int EXTRA_W   = $clog2(MAX_EXTRA + 1);

  localparam logic [7:0] OPC_MOVAB = 8'h78;
  localparam logic [7:0] OPC_MVIA  = 8'h3E;
  localparam logic [7:0] OPC_MVIB  = 8'h06;
  localparam logic [7:0] OPC_LXIH  = 8'h21;
  localparam logic [7:0] OPC_LDIND = 8'h7E;
  localparam logic [7:0] OPC_STIND = 8'h77;

  typedef struct packed {
    op_kind_e               kind;
    logic [EXTRA_W-1:0]     extra;  // cycles after the fetch
  } dec_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opcode,
  output dec_t          dec
);
  always_comb begin
    dec.kind  = OPK_NOP;
    dec.extra = '0;
    case (opcode[7:0])
      OPC_MOVAB: begin dec.kind = OPK_MOVAB; dec.extra = EXTRA_W'(0); end
      OPC_MVIA:  begin dec.kind = OPK_MVIA;  dec.extra = EXTRA_W'(1); end
      OPC_MVIB:  begin dec.kind = OPK_MVIB;  dec.extra = EXTRA_W'(1); end
      OPC_LXIH:  begin dec.kind = OPK_LXIH;  dec.extra = EXTRA_W'(2); end
      OPC_LDIND: begin dec.kind = OPK_LDIND; dec.extra = EXTRA_W'(1); end
      OPC_STIND: begin dec.kind = OPK_STIND; dec.extra = EXTRA_W'(1); end
      default:   begin dec.kind = OPK_NOP;   dec.extra = '0; end
    endcase
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile
  import seq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREGS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  reg_sel_e      wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  output logic [DW-1:0] rd_h,
  output logic [DW-1:0] rd_l
);
  localparam int SEL_W = $clog2(NREGS);

  logic [DW-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (wr_en && (SEL_W'(wr_sel) == SEL_W'(i))) begin
        regs[i] <= wr_data;
      end
    end
  end

  assign rd_a = regs[RS_A];
  assign rd_b = regs[RS_B];
  assign rd_h = regs[RS_H];
  assign rd_l = regs[RS_L];
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (step) pc <= pc + AW'(1);
  end
endmodule

// File: rtl/instr_mcycle_seq.sv
module instr_mcycle_seq
  import seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [1:0]      req_type,
  output logic [AW-1:0]   req_addr,
  output logic [DW-1:0]   req_wdata,
  input  logic            rsp_valid,
  input  logic [DW-1:0]   rsp_data,
  output logic            retire_valid,
  output logic [DW-1:0]   retire_opcode,
  output logic [TS_W-1:0] retire_tstates,
  output logic [AW-1:0]   pc_o,
  output logic [DW-1:0]   acc_o,
  output logic [DW-1:0]   breg_o,
  output logic [DW-1:0]   hreg_o,
  output logic [DW-1:0]   lreg_o
);
  typedef enum logic {ST_ISSUE, ST_WAIT} st_e;

  st_e                st_q;
  logic [EXTRA_W-1:0] step_q;
  logic [DW-1:0]      op_q;
  logic [TS_W-1:0]    ts_q;

  logic [DW-1:0]      dec_src;
  dec_t               dec;
  logic               done;
  logic               first;
  logic               last;
  logic               pc_step;
  logic [TS_W-1:0]    ts_next;
  logic               wr_en;
  reg_sel_e           wr_sel;
  logic [DW-1:0]      wr_data;
  mc_kind_e           kind_c;
  logic [AW-1:0]      hl_addr;

  assign first   = (step_q == '0);
  assign dec_src = first ? rsp_data : op_q;
  assign done    = (st_q == ST_WAIT) && rsp_valid;
  assign last    = (step_q == dec.extra);
  assign ts_next = ts_q + (first ? TS_W'(T_FETCH) : TS_W'(T_MEM));
  assign hl_addr = AW'({hreg_o, lreg_o});

  seq_decode #(.DW(DW)) u_dec (
    .opcode (dec_src),
    .dec    (dec)
  );

  seq_pc #(.AW(AW)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .step (pc_step),
    .pc   (pc_o)
  );

  seq_regfile #(.DW(DW), .NREGS(4)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_a    (acc_o),
    .rd_b    (breg_o),
    .rd_h    (hreg_o),
    .rd_l    (lreg_o)
  );

  // request formation
  always_comb begin
    kind_c    = MC_FETCH;
    req_addr  = pc_o;
    req_wdata = '0;
    if (!first) begin
      case (dec.kind)
        OPK_LDIND: begin kind_c = MC_MEMRD; req_addr = hl_addr; end
        OPK_STIND: begin
          kind_c    = MC_MEMWR;
          req_addr  = hl_addr;
          req_wdata = acc_o;
        end
        default:   begin kind_c = MC_MEMRD; req_addr = pc_o; end
      endcase
    end
  end

  assign req_valid = (st_q == ST_ISSUE);
  assign req_type  = kind_c;

  // counter step: opcode bytes and immediate bytes
  always_comb begin
    pc_step = 1'b0;
    if (done) begin
      if (first) pc_step = 1'b1;
      else if (dec.kind == OPK_MVIA || dec.kind == OPK_MVIB ||
               dec.kind == OPK_LXIH) pc_step = 1'b1;
    end
  end

  // register writes
  always_comb begin
    wr_en   = 1'b0;
    wr_sel  = RS_A;
    wr_data = rsp_data;
    if (done) begin
      if (first) begin
        if (dec.kind == OPK_MOVAB) begin
          wr_en   = 1'b1;
          wr_sel  = RS_A;
          wr_data = breg_o;
        end
      end else begin
        case (dec.kind)
          OPK_MVIA, OPK_LDIND: begin wr_en = 1'b1; wr_sel = RS_A; end
          OPK_MVIB:            begin wr_en = 1'b1; wr_sel = RS_B; end
          OPK_LXIH: begin
            wr_en  = 1'b1;
            wr_sel = (step_q == EXTRA_W'(1)) ? RS_L : RS_H;
          end
          default: wr_en = 1'b0;
        endcase
      end
    end
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_ISSUE;
      step_q         <= '0;
      op_q           <= '0;
      ts_q           <= '0;
      retire_valid   <= 1'b0;
      retire_opcode  <= '0;
      retire_tstates <= '0;
    end else begin
      retire_valid <= 1'b0;
      case (st_q)
        ST_ISSUE: if (req_ready) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_valid) begin
            st_q <= ST_ISSUE;
            if (first) op_q <= rsp_data;
            if (last) begin
              retire_valid   <= 1'b1;
              retire_opcode  <= first ? rsp_data : op_q;
              retire_tstates <= ts_next;
              step_q         <= '0;
              ts_q           <= '0;
            end else begin
              step_q <= step_q + EXTRA_W'(1);
              ts_q   <= ts_next;
            end
          end
        end
        default: st_q <= ST_ISSUE;
      endcase
    end
  end
endmodule

// File: rtl/instr_mcycle_seq_chk.sv
module instr_mcycle_seq_chk #(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_type,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          rsp_valid,
  input logic          retire_valid,
  input logic [TW-1:0] retire_tstates,
  input logic [AW-1:0] pc_o
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst)                         pending <= 1'b0;
    else if (req_valid && req_ready) pending <= 1'b1;
    else if (rsp_valid)              pending <= 1'b0;
  end

  p_first_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (req_valid && req_type == 2'd0 && req_addr == '0));

  p_hold_req_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_type) &&
                                   $stable(req_addr) && $stable(req_wdata)));

  p_quiet_while_pending_r2: assert property (@(posedge clk) disable iff (rst)
    pending |-> !req_valid);

  p_pc_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (pc_o != $past(pc_o)) |-> (pc_o == $past(pc_o) + AW'(1)));

  p_retire_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    retire_valid |=> !retire_valid);

  p_retire_len_r11: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> (retire_tstates == TW'(4) || retire_tstates == TW'(7) ||
                      retire_tstates == TW'(10)));
endmodule

bind instr_mcycle_seq instr_mcycle_seq_chk #(
  .DW(DW), .AW(AW), .TW(seq_pkg::TS_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_type       (req_type),
  .req_addr       (req_addr),
  .req_wdata      (req_wdata),
  .rsp_valid      (rsp_valid),
  .retire_valid   (retire_valid),
  .retire_tstates (retire_tstates),
  .pc_o           (pc_o)
);

// File: tb/instr_mcycle_seq_tb.sv
module instr_mcycle_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [1:0]  req_type;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = 8'h00;
  logic        retire_valid;
  logic [7:0]  retire_opcode;
  logic [3:0]  retire_tstates;
  logic [15:0] pc_o;
  logic [7:0]  acc_o, breg_o, hreg_o, lreg_o;

  always #10 clk = ~clk;  // 50 MHz

  instr_mcycle_seq dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .retire_valid(retire_valid), .retire_opcode(retire_opcode),
    .retire_tstates(retire_tstates),
    .pc_o(pc_o), .acc_o(acc_o), .breg_o(breg_o), .hreg_o(hreg_o), .lreg_o(lreg_o)
  );

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  logic [7:0]  mem [256];
  logic [15:0] m_pc;
  logic [7:0]  m_a, m_b, m_h, m_l;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int extra_of(input logic [7:0] op);
    case (op)
      8'h3E, 8'h06, 8'h7E, 8'h77: return 1;
      8'h21: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int tstates_of(input logic [7:0] op);
    return 4 + 3 * extra_of(op);
  endfunction

  // plays one bus cycle; called and returns at a falling edge
  task automatic serve(input logic [1:0] et, input logic [15:0] ea,
                       input logic [7:0] ew, output logic [7:0] got);
    int k, m;
    check(req_valid == 1'b1, "R2 req offered", req_valid, 1);
    check(req_type == et, "R3 req_type", req_type, et);
    check(req_addr == ea, "R3 req_addr", req_addr, ea);
    if (et == 2'd2) check(req_wdata == ew, "R9 write data", req_wdata, ew);
    k = $urandom_range(0, 2);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      check(req_valid && req_addr == ea && req_type == et, "R2 held", req_addr, ea);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check(req_valid == 1'b0, "R2 drop after accept", req_valid, 0);
    m = $urandom_range(0, 3);
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      check(req_valid == 1'b0, "R2 quiet until done", req_valid, 0);
    end
    if (et == 2'd2) begin
      mem[ea[7:0]] = ew;
      got = 8'($urandom);
    end else begin
      got = mem[ea[7:0]];
    end
    rsp_valid = 1'b1;
    rsp_data  = got;
    @(negedge clk);
    rsp_valid = 1'b0;
    rsp_data  = 8'($urandom);
  endtask

  task automatic run_instr();
    logic [7:0] op, d;
    int n;
    op = mem[m_pc[7:0]];
    n  = extra_of(op);
    serve(2'd0, m_pc, 8'h00, op);
    m_pc = m_pc + 16'd1;
    if (n == 0) begin
      if (op == 8'h78) m_a = m_b;
    end else begin
      check(retire_valid == 1'b0, "R11 no early retire", retire_valid, 0);
      case (op)
        8'h3E: begin serve(2'd1, m_pc, 8'h00, d); m_pc++; m_a = d; end
        8'h06: begin serve(2'd1, m_pc, 8'h00, d); m_pc++; m_b = d; end
        8'h21: begin
          serve(2'd1, m_pc, 8'h00, d); m_pc++; m_l = d;
          check(retire_valid == 1'b0, "R7 no retire mid", retire_valid, 0);
          check(lreg_o == m_l, "R7 low byte first", lreg_o, m_l);
          serve(2'd1, m_pc, 8'h00, d); m_pc++; m_h = d;
        end
        8'h7E: begin serve(2'd1, {m_h, m_l}, 8'h00, d); m_a = d; end
        default: serve(2'd2, {m_h, m_l}, m_a, d);  // 77h
      endcase
    end
    check(retire_valid == 1'b1, "R11 retire pulse", retire_valid, 1);
    check(retire_opcode == op, "R11 retire opcode", retire_opcode, op);
    case (op)
      8'h78: check(retire_tstates == 4'(tstates_of(op)), "R4 tstates", retire_tstates, tstates_of(op));
      8'h3E: check(retire_tstates == 4'(tstates_of(op)), "R5 tstates", retire_tstates, tstates_of(op));
      8'h06: check(retire_tstates == 4'(tstates_of(op)), "R6 tstates", retire_tstates, tstates_of(op));
      8'h21: check(retire_tstates == 4'(tstates_of(op)), "R7 tstates", retire_tstates, tstates_of(op));
      8'h7E: check(retire_tstates == 4'(tstates_of(op)), "R8 tstates", retire_tstates, tstates_of(op));
      8'h77: check(retire_tstates == 4'(tstates_of(op)), "R9 tstates", retire_tstates, tstates_of(op));
      default: check(retire_tstates == 4'(tstates_of(op)), "R10 tstates", retire_tstates, tstates_of(op));
    endcase
    check(pc_o == m_pc, "R3 pc", pc_o, m_pc);
    check(acc_o == m_a, "R4 R5 R8 R10 reg A", acc_o, m_a);
    check(breg_o == m_b, "R6 R10 reg B", breg_o, m_b);
    check(hreg_o == m_h && lreg_o == m_l, "R7 R10 reg HL", {hreg_o, lreg_o}, {m_h, m_l});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(pc_o == 16'h0 && acc_o == 8'h0 && breg_o == 8'h0, "R1 regs in reset",
          {pc_o, acc_o, breg_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(retire_valid == 1'b0, "R1 no retire", retire_valid, 0);
    check(hreg_o == 8'h0 && lreg_o == 8'h0 && pc_o == 16'h0, "R1 HL pc zero",
          {hreg_o, lreg_o, pc_o}, 0);
    check(req_valid && req_type == 2'd0 && req_addr == 16'h0, "R1 first fetch",
          {req_valid, req_type, req_addr}, {1'b1, 2'd0, 16'h0});
    m_pc = 16'h0; m_a = 8'h0; m_b = 8'h0; m_h = 8'h0; m_l = 8'h0;
  endtask

  function automatic logic [7:0] pick_op();
    int s;
    logic [7:0] o;
    s = $urandom_range(0, 6);
    case (s)
      0: return 8'h78;
      1: return 8'h3E;
      2: return 8'h06;
      3: return 8'h21;
      4: return 8'h7E;
      5: return 8'h77;
      default: begin
        o = 8'($urandom);
        if (extra_of(o) != 0 || o == 8'h78) o = 8'h00;
        return o;
      end
    endcase
  endfunction

  initial begin
    int p;
    logic [7:0] o;
    void'($urandom(32'h0000_5eed));
    for (int run = 0; run < 4; run++) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
      p = 0;
      // HL must point into the data area before any indirect access
      mem[0] = 8'h21; mem[1] = 8'hF0; mem[2] = 8'hA0; p = 3;
      if (run == 0) begin
        // directed: immediate B, copy, immediate A, store, clear, load back, unknowns
        mem[3]  = 8'h06; mem[4] = 8'h43;
        mem[5]  = 8'h78;
        mem[6]  = 8'h3E; mem[7] = 8'h45;
        mem[8]  = 8'h77;
        mem[9]  = 8'h3E; mem[10] = 8'h00;
        mem[11] = 8'h7E;
        mem[12] = 8'hFF;
        mem[13] = 8'h00;
        p = 14;
      end
      while (p < 8'hC8) begin
        o = pick_op();
        mem[p] = o; p++;
        if (o == 8'h21) begin
          mem[p] = 8'hE0 | 8'($urandom_range(0, 31)); p++;
          mem[p] = 8'($urandom); p++;
        end else if (extra_of(o) == 1 && (o == 8'h3E || o == 8'h06)) begin
          mem[p] = 8'($urandom); p++;
        end
      end
      do_reset();
      while (int'(m_pc) < p) run_instr();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule